// File: doc/BRIEF.md
# Matrix Keypad Row Scan Engine

This block walks a keyboard matrix of up to 16 rows and 8 columns one row at a time. It drives a single row high and reads back the column lines. A column reading 1 means the key at that crossing is closed. Each driven row is held long enough to filter contact bounce. When every active row has been visited, the engine lists the keys it found as a short burst of key-down events and raises a one-cycle end-of-scan strobe. It then waits a programmable gap before the next pass.

Software picks the active rows, the debounce length and the gap between passes. A per-key wake mask chooses which closed keys may raise the wake request. All timing counts are in cycles of the slow scan clock. Dropping the enable input aborts the current pass at once. Raising it again starts a fresh pass.

Top module: `kps_scan_engine`

## Requirements
- R1: While `enable` is low, and after reset, `row_drive`, `key_valid`, `scan_done` and `wake_req` are all 0 from the cycle after `enable` is sampled low.
- R2: After `enable` is first sampled high, exactly 5 cycles pass with no row driven before the first active row is driven. Every later pass also opens with these 5 idle cycles.
- R3: At most one bit of `row_drive` is set at any time (bit r drives row r). Each active row stays driven for exactly 16 + `debounce_cnt` consecutive cycles.
- R4: Rows whose `row_active` bit is 0 are never driven and take no scan time. Keys on those rows are never reported.
- R5: A key is down only if its column reads 1 on every cycle of its row's drive window. A single-cycle dropout anywhere in the window removes that key from the pass.
- R6: After the last active row, the found keys are emitted one per cycle on `key_valid`/`key_row`/`key_col`, with no row driven. The cycle after the last event (or straight after the rows if none were found), `scan_done` pulses for one cycle, never together with `key_valid`.
- R7: Within a pass, events come out in ascending order of the scan code row*8 + column: by row first, then by column.
- R8: A pass reports at most 8 keys. Those with the 8 lowest scan codes are kept and the rest are dropped for that pass.
- R9: Between passes the engine idles for `repeat_dly` cycles. Two consecutive `scan_done` pulses are therefore `repeat_dly` + 6 + N*(16 + `debounce_cnt`) + K cycles apart, where N is the number of active rows and K the number of keys reported in the later pass.
- R10: `wake_req` is updated in the cycle of each `scan_done` pulse and held until the next one. It is 1 when some key found down in that pass, dropped keys included, has a 0 in `wake_mask` bit row*8 + column. A mask bit of 1 keeps that key from waking.
- R11: Clearing `enable` in the middle of a pass discards it: no events and no `scan_done` come from it. Setting `enable` again restarts from the 5-cycle start delay.
- R12: The full 10-bit debounce range is honoured: with `debounce_cnt` = 0x3FF a row is driven for 1039 cycles and its keys are still reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Scan enable; low stops and clears the engine |
| debounce_cnt | input | 10 | Extra cycles added to each row's 16-cycle drive window |
| repeat_dly | input | 16 | Idle cycles between the end of one pass and the next start delay |
| row_active | input | 16 | Bit r set: row r is part of the scan |
| wake_mask | input | 128 | Bit row*8+col: 1 keeps that key from raising the wake request |
| col_in | input | 8 | Column readback, 1 = key closed on the driven row |
| row_drive | output | 16 | One-hot row drive, all zero between rows |
| key_valid | output | 1 | A key-down event is presented this cycle |
| key_row | output | 4 | Row of the event |
| key_col | output | 3 | Column of the event |
| scan_done | output | 1 | One-cycle end-of-pass strobe |
| wake_req | output | 1 | Wake request from the last completed pass |

## Verification
Every result here falls on a fixed cycle count after its cause. The first row rises 5 cycles after enable, and each row window lasts 16 plus the debounce count. Events follow the last row one per cycle, and the strobe comes one cycle after the last event. The bench samples every output on the falling edge and counts those edges from the stimulus. It compares the counted start delay, row widths and strobe spacing against the formulas in R2, R3 and R9. Event lists and the wake level are checked at the strobe edge against a list the bench builds itself from its key matrix, active rows and masks.

// File: rtl/kps_pkg.sv
package kps_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LEAD,
    SQ_ROW,
    SQ_REPORT,
    SQ_GAP
  } seq_state_e;

  localparam int unsigned LEAD_CYCLES     = 5;
  localparam int unsigned ROW_BASE_CYCLES = 16;
endpackage

// File: rtl/kps_sequencer.sv
module kps_sequencer
  import kps_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int DBW  = 10,
  parameter int RPTW = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic [DBW-1:0]          debounce_cnt,
  input  logic [RPTW-1:0]         repeat_dly,
  input  logic [ROWS-1:0]         row_active,
  input  logic                    report_done,
  output logic [ROWS-1:0]         row_drive,
  output logic [$clog2(ROWS)-1:0] cur_row,
  output logic                    row_first,
  output logic                    row_sample,
  output logic                    row_last,
  output logic                    lead_active,
  output logic                    reporting
);
  localparam int RW = $clog2(ROWS);
  localparam int CW = (RPTW > DBW + 1) ? RPTW : DBW + 1;

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [RW-1:0] row_q, row_d;

  logic [RW:0]   base;
  logic          found;
  logic [RW-1:0] pick;
  logic [CW-1:0] win_end;
  logic          lead_last, win_last, gap_last;

  // search for the lowest active row at or above base
  always_comb begin
    base  = (state_q == SQ_ROW) ? ({1'b0, row_q} + 1'b1) : '0;
    found = 1'b0;
    pick  = '0;
    for (int r = ROWS - 1; r >= 0; r--) begin
      if (row_active[r] && ((RW+1)'(r) >= base)) begin
        found = 1'b1;
        pick  = RW'(r);
      end
    end
  end

  assign win_end   = CW'(ROW_BASE_CYCLES - 1) + CW'(debounce_cnt);
  assign lead_last = (cnt_q == CW'(LEAD_CYCLES - 1));
  assign win_last  = (cnt_q == win_end);
  assign gap_last  = ((cnt_q + CW'(1)) == CW'(repeat_dly));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    row_d   = row_q;
    if (!enable) begin
      state_d = SQ_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          state_d = SQ_LEAD;
          cnt_d   = '0;
        end
        SQ_LEAD: begin
          if (lead_last) begin
            cnt_d   = '0;
            state_d = found ? SQ_ROW : SQ_REPORT;
            if (found) row_d = pick;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        SQ_ROW: begin
          if (win_last) begin
            cnt_d   = '0;
            state_d = found ? SQ_ROW : SQ_REPORT;
            if (found) row_d = pick;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        SQ_REPORT: begin
          if (report_done) begin
            cnt_d   = '0;
            state_d = (repeat_dly != '0) ? SQ_GAP : SQ_LEAD;
          end
        end
        SQ_GAP: begin
          if (gap_last) begin
            cnt_d   = '0;
            state_d = SQ_LEAD;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        default: begin
          state_d = SQ_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      row_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      row_q   <= row_d;
    end
  end

  always_comb begin
    row_drive = '0;
    if (state_q == SQ_ROW) row_drive[row_q] = 1'b1;
  end

  assign cur_row     = row_q;
  assign row_sample  = (state_q == SQ_ROW);
  assign row_first   = row_sample && (cnt_q == '0);
  assign row_last    = row_sample && win_last;
  assign lead_active = (state_q == SQ_LEAD);
  assign reporting   = (state_q == SQ_REPORT);
endmodule

// File: rtl/kps_debounce.sv
module kps_debounce #(
  parameter int COLS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sample_en,
  input  logic            first,
  input  logic [COLS-1:0] col_in,
  output logic [COLS-1:0] stable
);
  logic [COLS-1:0] acc_q;
  logic [COLS-1:0] acc_d;

  // a column survives only while every sample of the window reads 1
  always_comb begin
    stable = (first ? {COLS{1'b1}} : acc_q) & col_in;
    acc_d  = sample_en ? stable : acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/kps_collect.sv
module kps_collect #(
  parameter int ROWS = 16,
  parameter int COLS = 8,
  parameter int MAXK = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic                    clear,
  input  logic                    row_last,
  input  logic [$clog2(ROWS)-1:0] cur_row,
  input  logic [COLS-1:0]         stable,
  input  logic [ROWS*COLS-1:0]    wake_mask,
  input  logic                    reporting,
  output logic                    report_done,
  output logic                    key_valid,
  output logic [$clog2(ROWS)-1:0] key_row,
  output logic [$clog2(COLS)-1:0] key_col,
  output logic                    scan_done,
  output logic                    wake_req
);
  localparam int RW  = $clog2(ROWS);
  localparam int CLW = $clog2(COLS);
  localparam int EW  = RW + CLW;
  localparam int NW  = $clog2(MAXK + 1);
  localparam int IW  = $clog2(MAXK);

  logic [EW-1:0] code_q [MAXK];
  logic [EW-1:0] code_d [MAXK];
  logic [NW-1:0] cnt_q, cnt_d;
  logic [NW-1:0] idx_q, idx_d;
  logic          wacc_q, wacc_d;
  logic          hit;
  logic          valid_q, valid_d;
  logic [EW-1:0] out_q, out_d;
  logic          done_q, done_d;
  logic          wake_q, wake_d;

  // append this row's debounced keys in column order, saturating at MAXK
  always_comb begin
    logic [NW-1:0] n;
    code_d = code_q;
    n      = cnt_q;
    hit    = 1'b0;
    if (clear) begin
      n = '0;
    end else if (row_last) begin
      for (int c = 0; c < COLS; c++) begin
        if (stable[c]) begin
          if (!wake_mask[int'(cur_row) * COLS + c]) hit = 1'b1;
          if (n < NW'(MAXK)) begin
            code_d[n[IW-1:0]] = {cur_row, CLW'(c)};
            n = n + NW'(1);
          end
        end
      end
    end
    cnt_d  = n;
    wacc_d = clear ? 1'b0 : (wacc_q | hit);
  end

  assign report_done = reporting && (idx_q == cnt_q);

  always_comb begin
    idx_d   = reporting ? (report_done ? idx_q : idx_q + NW'(1)) : '0;
    valid_d = enable && reporting && !report_done;
    out_d   = valid_d ? code_q[idx_q[IW-1:0]] : out_q;
    done_d  = enable && report_done;
    wake_d  = !enable ? 1'b0 : (report_done ? wacc_q : wake_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAXK; i++) code_q[i] <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      wacc_q  <= 1'b0;
      valid_q <= 1'b0;
      out_q   <= '0;
      done_q  <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      for (int i = 0; i < MAXK; i++) code_q[i] <= code_d[i];
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      wacc_q  <= wacc_d;
      valid_q <= valid_d;
      out_q   <= out_d;
      done_q  <= done_d;
      wake_q  <= wake_d;
    end
  end

  assign key_valid = valid_q;
  assign key_row   = out_q[EW-1:CLW];
  assign key_col   = out_q[CLW-1:0];
  assign scan_done = done_q;
  assign wake_req  = wake_q;
endmodule

// File: rtl/kps_scan_engine.sv
module kps_scan_engine #(
  parameter int ROWS = 16,
  parameter int COLS = 8,
  parameter int DBW  = 10,
  parameter int RPTW = 16,
  parameter int MAXK = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic [DBW-1:0]          debounce_cnt,
  input  logic [RPTW-1:0]         repeat_dly,
  input  logic [ROWS-1:0]         row_active,
  input  logic [ROWS*COLS-1:0]    wake_mask,
  input  logic [COLS-1:0]         col_in,
  output logic [ROWS-1:0]         row_drive,
  output logic                    key_valid,
  output logic [$clog2(ROWS)-1:0] key_row,
  output logic [$clog2(COLS)-1:0] key_col,
  output logic                    scan_done,
  output logic                    wake_req
);
  localparam int RW = $clog2(ROWS);

  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic [RW-1:0]   cur_row;
  logic            row_first, row_sample, row_last;
  logic            lead_active, reporting, report_done;
  logic [COLS-1:0] stable;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  kps_sequencer #(.ROWS(ROWS), .DBW(DBW), .RPTW(RPTW)) u_seq (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .enable       (enable),
    .debounce_cnt (debounce_cnt),
    .repeat_dly   (repeat_dly),
    .row_active   (row_active),
    .report_done  (report_done),
    .row_drive    (row_drive),
    .cur_row      (cur_row),
    .row_first    (row_first),
    .row_sample   (row_sample),
    .row_last     (row_last),
    .lead_active  (lead_active),
    .reporting    (reporting)
  );

  kps_debounce #(.COLS(COLS)) u_deb (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sample_en (row_sample),
    .first     (row_first),
    .col_in    (col_in),
    .stable    (stable)
  );

  kps_collect #(.ROWS(ROWS), .COLS(COLS), .MAXK(MAXK)) u_col (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .enable      (enable),
    .clear       (lead_active),
    .row_last    (row_last),
    .cur_row     (cur_row),
    .stable      (stable),
    .wake_mask   (wake_mask),
    .reporting   (reporting),
    .report_done (report_done),
    .key_valid   (key_valid),
    .key_row     (key_row),
    .key_col     (key_col),
    .scan_done   (scan_done),
    .wake_req    (wake_req)
  );
endmodule

// File: rtl/kps_scan_engine_chk.sv
module kps_scan_engine_chk #(
  parameter int ROWS = 16,
  parameter int COLS = 8,
  parameter int MAXK = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    enable,
  input logic [ROWS-1:0]         row_drive,
  input logic                    key_valid,
  input logic [$clog2(ROWS)-1:0] key_row,
  input logic [$clog2(COLS)-1:0] key_col,
  input logic                    scan_done,
  input logic                    wake_req
);
  localparam int NW = $clog2(MAXK + 1) + 1;

  logic [NW-1:0] kcnt_q;
  logic [3:0]    zrun_q;
  logic          any_row;

  assign any_row = |row_drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     kcnt_q <= '0;
    else if (scan_done || !enable)  kcnt_q <= '0;
    else if (key_valid)             kcnt_q <= kcnt_q + NW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          zrun_q <= '0;
    else if (any_row)    zrun_q <= '0;
    else if (zrun_q != 4'hF) zrun_q <= zrun_q + 4'd1;
  end

  assert_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (row_drive == '0 && !key_valid && !scan_done && !wake_req));

  assert_lead_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(any_row) |-> (zrun_q >= 4'd5));

  assert_one_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_drive));

  assert_report_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> (row_drive == '0));

  assert_done_alone_R6: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> !key_valid);

  assert_ascending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && $past(key_valid)) |-> ({key_row, key_col} > $past({key_row, key_col})));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> (kcnt_q < NW'(MAXK)));
endmodule

bind kps_scan_engine kps_scan_engine_chk #(.ROWS(ROWS), .COLS(COLS), .MAXK(MAXK)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .row_drive (row_drive),
  .key_valid (key_valid),
  .key_row   (key_row),
  .key_col   (key_col),
  .scan_done (scan_done),
  .wake_req  (wake_req)
);

// File: tb/kps_scan_engine_bench.sv
module kps_scan_engine_bench;
  logic         clk;
  logic         rst_n;
  logic         enable;
  logic [9:0]   debounce_cnt;
  logic [15:0]  repeat_dly;
  logic [15:0]  row_active;
  logic [127:0] wake_mask;
  logic [7:0]   col_in;
  logic [15:0]  row_drive;
  logic         key_valid;
  logic [3:0]   key_row;
  logic [2:0]   key_col;
  logic         scan_done;
  logic         wake_req;
  logic [127:0] keys;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int ev_code [0:255];
  int ev_n = 0;
  int done_n = 0;
  int last_done_cyc = 0;
  int prev_done_cyc = 0;
  logic done_wake = 1'b0;
  int exp_code [0:127];
  int exp_n;
  logic exp_wake;

  kps_scan_engine u_kps_scan_engine (
    .clk(clk), .rst_n(rst_n), .enable(enable), .debounce_cnt(debounce_cnt),
    .repeat_dly(repeat_dly), .row_active(row_active), .wake_mask(wake_mask),
    .col_in(col_in), .row_drive(row_drive), .key_valid(key_valid),
    .key_row(key_row), .key_col(key_col), .scan_done(scan_done), .wake_req(wake_req)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // key matrix: driven row connects to the columns of its closed keys
  always_comb begin
    col_in = '0;
    for (int r = 0; r < 16; r++)
      if (row_drive[r]) col_in = col_in | keys[r*8 +: 8];
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog all actual=%0d expected<190000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (key_valid && ev_n < 256) begin
      ev_code[ev_n] = int'({key_row, key_col});
      ev_n = ev_n + 1;
    end
    if (scan_done) begin
      prev_done_cyc = last_done_cyc;
      last_done_cyc = cyc;
      done_wake = wake_req;
      done_n = done_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic calc_expect();
    exp_n = 0;
    exp_wake = 1'b0;
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 8; c++)
        if (row_active[r] && keys[r*8+c]) begin
          if (!wake_mask[r*8+c]) exp_wake = 1'b1;
          if (exp_n < 8) begin
            exp_code[exp_n] = r*8 + c;
            exp_n = exp_n + 1;
          end
        end
  endtask

  task automatic restart();
    @(negedge clk);
    enable = 1'b0;
    repeat (3) @(negedge clk);
    enable = 1'b1;
  endtask

  task automatic wait_scan();
    int d0 = done_n;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (done_n > d0) break;
    end
  endtask

  task automatic scan_and_compare(input string req);
    int s0 = ev_n;
    calc_expect();
    wait_scan();
    chk((ev_n - s0) == exp_n, req, ev_n - s0, exp_n, "event count");
    for (int i = 0; i < exp_n && i < ev_n - s0; i++)
      chk(ev_code[s0+i] == exp_code[i], req, ev_code[s0+i], exp_code[i], "scan code");
  endtask

  function automatic logic [127:0] key_at(input int r, input int c);
    logic [127:0] v = '0;
    v[r*8+c] = 1'b1;
    return v;
  endfunction

  task automatic t_reset();
    chk(row_drive == '0 && !key_valid && !scan_done && !wake_req, "R1", int'(row_drive), 0, "outputs after reset");
    repeat (20) @(negedge clk);
    chk(row_drive == '0 && ev_n == 0 && done_n == 0, "R1", ev_n + done_n, 0, "idle with enable low");
  endtask

  task automatic t_lead_width();
    int z = 0;
    int w = 1;
    row_active = 16'h0001; keys = '0; debounce_cnt = 10'd0; repeat_dly = 16'd0;
    restart();
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (row_drive != '0) break;
      z++;
    end
    chk(z == 5, "R2", z, 5, "start delay cycles");
    chk(row_drive == 16'h0001, "R3", int'(row_drive), 1, "driven row");
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (row_drive != 16'h0001) break;
      w++;
    end
    chk(w == 16, "R3", w, 16, "row width debounce 0");
    debounce_cnt = 10'd7;
    restart();
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (row_drive != '0) break;
    end
    w = 1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (row_drive != 16'h0001) break;
      w++;
    end
    chk(w == 23, "R3", w, 23, "row width debounce 7");
  endtask

  task automatic t_basic();
    row_active = 16'hFFFF; debounce_cnt = 10'd2; repeat_dly = 16'd20;
    keys = key_at(15,7) | key_at(0,2) | key_at(12,5) | key_at(3,6) | key_at(3,0);
    restart();
    scan_and_compare("R6/R7 first pass");
    scan_and_compare("R7 second pass");
    chk(last_done_cyc - prev_done_cyc == 20 + 6 + 16*18 + 5, "R9",
        last_done_cyc - prev_done_cyc, 20 + 6 + 16*18 + 5, "pass period");
  endtask

  task automatic t_skip();
    row_active = 16'h8204; debounce_cnt = 10'd0; repeat_dly = 16'd3;
    keys = key_at(1,1) | key_at(2,4) | key_at(9,0) | key_at(15,2) | key_at(14,5);
    restart();
    scan_and_compare("R4 sparse rows");
    scan_and_compare("R4 sparse rows again");
    chk(last_done_cyc - prev_done_cyc == 3 + 6 + 3*16 + 3, "R4",
        last_done_cyc - prev_done_cyc, 3 + 6 + 3*16 + 3, "skipped rows take no time");
  endtask

  task automatic t_overflow();
    row_active = 16'hFFFF; debounce_cnt = 10'd0; repeat_dly = 16'd0;
    wake_mask = '1;
    keys = key_at(0,0) | key_at(0,7) | key_at(2,3) | key_at(2,4) | key_at(4,1) |
           key_at(6,6) | key_at(7,0) | key_at(8,2) | key_at(10,5) | key_at(13,3) | key_at(15,1);
    wake_mask[15*8+1] = 1'b0;
    restart();
    scan_and_compare("R8 cap at eight");
    chk(done_wake == 1'b1, "R10", int'(done_wake), 1, "wake from dropped key");
  endtask

  task automatic t_wake();
    row_active = 16'hFFDF; debounce_cnt = 10'd0; repeat_dly = 16'd0;
    keys = key_at(5,3) | key_at(9,6);
    wake_mask = '1;
    restart();
    wait_scan();
    chk(done_wake == 1'b0, "R10", int'(done_wake), 0, "all masked");
    wake_mask[5*8+3] = 1'b0;
    restart();
    wait_scan();
    chk(done_wake == 1'b0, "R10", int'(done_wake), 0, "unmasked key on inactive row");
    row_active = 16'hFFFF;
    restart();
    wait_scan();
    chk(done_wake == 1'b1, "R10", int'(done_wake), 1, "unmasked key pressed");
    chk(wake_req == 1'b1, "R10", int'(wake_req), 1, "wake held after strobe");
    keys = '0;
    wait_scan();
    chk(done_wake == 1'b0, "R10", int'(done_wake), 0, "wake drops after release");
    wake_mask = '1;
  endtask

  task automatic t_bounce();
    int s0;
    row_active = 16'h0008; debounce_cnt = 10'd4; repeat_dly = 16'd2;
    keys = key_at(3,1) | key_at(3,4);
    restart();
    s0 = ev_n;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (row_drive[3]) break;
    end
    repeat (7) @(negedge clk);
    keys[3*8+4] = 1'b0;
    @(negedge clk);
    keys[3*8+4] = 1'b1;
    wait_scan();
    chk(ev_n - s0 == 1, "R5", ev_n - s0, 1, "bounced key removed count");
    chk(ev_code[s0] == 25, "R5", ev_code[s0], 25, "stable key kept");
    scan_and_compare("R5 steady pass");
  endtask

  task automatic t_abort();
    int s0;
    int d0;
    int z = 0;
    row_active = 16'hFFFF; debounce_cnt = 10'd0; repeat_dly = 16'd5;
    keys = key_at(1,1) | key_at(9,2);
    restart();
    s0 = ev_n; d0 = done_n;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (row_drive[4]) break;
    end
    enable = 1'b0;
    @(negedge clk);
    chk(row_drive == '0, "R11", int'(row_drive), 0, "rows released on abort");
    repeat (30) @(negedge clk);
    chk(ev_n == s0 && done_n == d0, "R11", (ev_n - s0) + (done_n - d0), 0, "no output from aborted pass");
    enable = 1'b1;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (row_drive != '0) break;
      z++;
    end
    chk(z == 5, "R11", z, 5, "restart delay after re-enable");
    scan_and_compare("R11 clean pass");
  endtask

  task automatic t_maxdeb();
    int w = 1;
    row_active = 16'h0100; debounce_cnt = 10'h3FF; repeat_dly = 16'd0;
    keys = key_at(8,7);
    restart();
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (row_drive != '0) break;
    end
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (row_drive != 16'h0100) break;
      w++;
    end
    chk(w == 1039, "R12", w, 1039, "row width at max debounce");
    scan_and_compare("R12 key at max debounce");
  endtask

  initial begin
    rst_n = 1'b0; enable = 1'b0; debounce_cnt = '0; repeat_dly = '0;
    row_active = '0; wake_mask = '1; keys = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_lead_width();
    t_basic();
    t_skip();
    t_overflow();
    t_wake();
    t_bounce();
    t_abort();
    t_maxdeb();
    enable = 1'b0;
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule